// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a single memory access may proceed, given the attributes of an already matched translation entry and the current system control state. From the entry it takes a domain number, a three-bit access-permission code, a two-bit stage-2 permission field and an execute-never bit. From the request it takes the access kind (read, write or instruction fetch) and the privilege level. From the system it takes a packed word of two-bit domain modes, write-implies-execute-never controls and two legacy protection bits that give meaning to access-permission code 0.

The verdict is a grant bit, an abort kind (prefetch or data), a fault class (domain or permission) and a flag for unpredictable configurations. The decision logic is combinational. It is captured in one output register, so a verdict appears one clock after its inputs. Lookup and table walking sit outside the block. The block is placed between the entry match and the point where faults are raised.

Top module: `perm_gate`

## Requirements
- R1: While reset is asserted, and until the first clock edge after release, grant is 0, abort_kind is 2'b00 (none), fault_cls is 2'b00 (none) and unpred is 0.
- R2: All outputs show the verdict for the inputs sampled at the previous rising clock edge. The outputs do not change between edges.
- R3: The domain mode is the two-bit field dac_word[2*dom_id+1 : 2*dom_id]. Fields of other domains have no effect on the verdict.
- R4: Mode 0 (no access) denies the access with fault_cls 2'b01 (domain). abort_kind is 2'b01 (prefetch) when acc_kind is 2'b10 (fetch), and 2'b10 (data) for any other acc_kind. acc_kind 2'b00 and 2'b11 are reads, and 2'b01 is a write.
- R5: Mode 3 (manager) grants the access whatever the values of ap_code, hap_bits, xn_bit and the control bits.
- R6: Mode 2 is unpredictable. It sets unpred and denies the access, and reports no abort and no fault class.
- R7: In mode 1 (client) with ap_code 0, legacy_prot selects the outcome. 2'b10 aborts on a write or on any unprivileged access. 2'b01 aborts on writes only. 2'b00 and 2'b11 abort every access. A page with ap_code 0 is not writable.
- R8: In client mode the other codes behave as follows.
  - Code 1 aborts unprivileged accesses, and the page is writable.
  - Code 2 aborts only unprivileged writes, and the page is writable only when priv is 1.
  - Code 3 never aborts, and the page is writable.
  - Code 5 aborts any unprivileged access and any write.
  - Codes 6 and 7 abort writes.
  - Codes 5, 6 and 7 are not writable.
  - Code 4 sets unpred and denies the access with no fault.
- R9: In client mode a write aborts when hap_bits[1] is 0. A read or a fetch aborts when hap_bits[0] is 0.
- R10: In client mode a fetch is execute-never when any one of these holds: xn_bit is 1; the page is writable and wxn_en is 1; or ap_code is 3, uwxn_en is 1 and priv is 1. An execute-never fetch is denied.
- R11: In client mode a fetch that has an access-permission abort, execute-never or a stage-2 abort gives abort_kind prefetch and fault_cls 2'b10 (permission). A non-fetch access with an access-permission or stage-2 abort gives abort_kind data and fault_cls permission. A domain fault takes priority over a permission fault. Only one class is reported, and a granted access has no abort and no class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_id | input | DOM_W (4) | Domain number of the matched entry |
| dac_word | input | 2*NUM_DOMAINS (32) | Packed two-bit modes, one per domain |
| ap_code | input | 3 | Access-permission code of the entry |
| hap_bits | input | 2 | Stage-2 permissions: bit 1 write, bit 0 read |
| xn_bit | input | 1 | Execute-never bit of the entry |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| priv | input | 1 | Access is privileged |
| wxn_en | input | 1 | Writable pages are execute-never |
| uwxn_en | input | 1 | Privileged fetch from code-3 pages is execute-never |
| legacy_prot | input | 2 | Meaning of ap_code 0 (bit 1 system, bit 0 rom) |
| grant | output | 1 | Access allowed |
| abort_kind | output | 2 | 00 none, 01 prefetch, 10 data |
| fault_cls | output | 2 | 00 none, 01 domain, 10 permission |
| unpred | output | 1 | Unpredictable configuration seen |

## Verification
The bench builds the block with its default of sixteen domains, so dom_id is four bits wide and dac_word is 32 bits wide. At this width the lowest domain (field bits 1:0) and the highest domain (field bits 31:30) can both be driven with neighbouring fields holding conflicting modes, which tests the field selection at both ends. Directed cases then cover every ap_code, every legacy_prot setting and both halves of hap_bits. A long stream of random inputs is compared every clock against a behavioural model that is one cycle behind the inputs.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    ACC_READ     = 2'b00,
    ACC_WRITE    = 2'b01,
    ACC_FETCH    = 2'b10,
    ACC_READ_ALT = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ABT_NONE     = 2'b00,
    ABT_PREFETCH = 2'b01,
    ABT_DATA     = 2'b10
  } abort_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'b00,
    FC_DOMAIN = 2'b01,
    FC_PERM   = 2'b10
  } fcls_e;

  typedef enum logic [1:0] {
    DM_NOACCESS = 2'b00,
    DM_CLIENT   = 2'b01,
    DM_RESERVED = 2'b10,
    DM_MANAGER  = 2'b11
  } dmode_e;

  typedef struct packed {
    logic   grant;
    abort_e abort;
    fcls_e  cls;
    logic   unpred;
  } verdict_t;

endpackage

// File: rtl/dom_mode_pick.sv
module dom_mode_pick
  import perm_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int DOM_W  = $clog2(NUM_DOMAINS),
  localparam int DAC_W  = 2 * NUM_DOMAINS
) (
  input  logic [DAC_W-1:0] dac_word,
  input  logic [DOM_W-1:0] dom_id,
  output dmode_e           mode
);

  logic [1:0] slot [NUM_DOMAINS];

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_slot
    assign slot[g] = dac_word[2*g +: 2];
  end

  assign mode = dmode_e'(slot[dom_id]);

endmodule

// File: rtl/ap_rules.sv
module ap_rules (
  input  logic [2:0] ap_code,
  input  logic [1:0] legacy_prot,
  input  logic       priv,
  input  logic       is_write,
  input  logic       xn_bit,
  input  logic       wxn_en,
  input  logic       uwxn_en,
  output logic       ap_abort,
  output logic       ap_unpred,
  output logic       xn_eff
);

  logic writable;

  always_comb begin
    ap_abort  = 1'b0;
    ap_unpred = 1'b0;
    writable  = 1'b1;
    case (ap_code)
      3'd0: begin
        writable = 1'b0;
        case (legacy_prot)
          2'b10:   ap_abort = is_write | ~priv;
          2'b01:   ap_abort = is_write;
          default: ap_abort = 1'b1;
        endcase
      end
      3'd1: ap_abort = ~priv;
      3'd2: begin
        ap_abort = ~priv & is_write;
        writable = priv;
      end
      3'd3: ap_abort = 1'b0;
      3'd4: begin
        ap_unpred = 1'b1;
        writable  = 1'b0;
      end
      3'd5: begin
        ap_abort = ~priv | is_write;
        writable = 1'b0;
      end
      default: begin
        ap_abort = is_write;
        writable = 1'b0;
      end
    endcase
  end

  assign xn_eff = xn_bit | (writable & wxn_en) |
                  ((ap_code == 3'd3) & uwxn_en & priv);

endmodule

// File: rtl/verdict_mux.sv
module verdict_mux
  import perm_pkg::*;
(
  input  dmode_e     mode,
  input  acc_e       acc,
  input  logic       ap_abort,
  input  logic       ap_unpred,
  input  logic       xn_eff,
  input  logic [1:0] hap_bits,
  output verdict_t   verdict
);

  logic is_fetch;
  logic is_write;
  logic hap_abort;

  assign is_fetch  = (acc == ACC_FETCH);
  assign is_write  = (acc == ACC_WRITE);
  assign hap_abort = is_write ? ~hap_bits[1] : ~hap_bits[0];

  always_comb begin
    verdict = '{grant: 1'b0, abort: ABT_NONE, cls: FC_NONE, unpred: 1'b0};
    case (mode)
      DM_NOACCESS: begin
        verdict.cls   = FC_DOMAIN;
        verdict.abort = is_fetch ? ABT_PREFETCH : ABT_DATA;
      end
      DM_MANAGER:  verdict.grant  = 1'b1;
      DM_RESERVED: verdict.unpred = 1'b1;
      default: begin
        if (ap_unpred) begin
          verdict.unpred = 1'b1;
        end else if (is_fetch && (ap_abort || xn_eff || hap_abort)) begin
          verdict.cls   = FC_PERM;
          verdict.abort = ABT_PREFETCH;
        end else if (!is_fetch && (ap_abort || hap_abort)) begin
          verdict.cls   = FC_PERM;
          verdict.abort = ABT_DATA;
        end else begin
          verdict.grant = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/perm_gate.sv
module perm_gate
  import perm_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int DOM_W = $clog2(NUM_DOMAINS),
  localparam int DAC_W = 2 * NUM_DOMAINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DOM_W-1:0] dom_id,
  input  logic [DAC_W-1:0] dac_word,
  input  logic [2:0]       ap_code,
  input  logic [1:0]       hap_bits,
  input  logic             xn_bit,
  input  logic [1:0]       acc_kind,
  input  logic             priv,
  input  logic             wxn_en,
  input  logic             uwxn_en,
  input  logic [1:0]       legacy_prot,
  output logic             grant,
  output logic [1:0]       abort_kind,
  output logic [1:0]       fault_cls,
  output logic             unpred
);

  dmode_e   mode;
  acc_e     acc;
  logic     ap_abort;
  logic     ap_unpred;
  logic     xn_eff;
  verdict_t v_next;
  verdict_t v_q;
  logic     primed_q;
  logic     primed_next;

  assign acc = acc_e'(acc_kind);

  dom_mode_pick #(.NUM_DOMAINS(NUM_DOMAINS)) u_pick (
    .dac_word (dac_word),
    .dom_id   (dom_id),
    .mode     (mode)
  );

  ap_rules u_rules (
    .ap_code     (ap_code),
    .legacy_prot (legacy_prot),
    .priv        (priv),
    .is_write    (acc == ACC_WRITE),
    .xn_bit      (xn_bit),
    .wxn_en      (wxn_en),
    .uwxn_en     (uwxn_en),
    .ap_abort    (ap_abort),
    .ap_unpred   (ap_unpred),
    .xn_eff      (xn_eff)
  );

  verdict_mux u_mux (
    .mode      (mode),
    .acc       (acc),
    .ap_abort  (ap_abort),
    .ap_unpred (ap_unpred),
    .xn_eff    (xn_eff),
    .hap_bits  (hap_bits),
    .verdict   (v_next)
  );

  assign primed_next = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= '0;
      primed_q <= 1'b0;
    end else begin
      v_q      <= v_next;
      primed_q <= primed_next;
    end
  end

  assign grant      = v_q.grant;
  assign abort_kind = v_q.abort;
  assign fault_cls  = v_q.cls;
  assign unpred     = v_q.unpred;

  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (abort_kind == ABT_NONE && fault_cls == FC_NONE)); // R11
  AST_ABORT_CLASS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_kind == ABT_NONE) == (fault_cls == FC_NONE)); // R11
  AST_NOACCESS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $past(mode == DM_NOACCESS) |-> fault_cls == FC_DOMAIN); // R4
  AST_MANAGER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $past(mode == DM_MANAGER) |-> grant); // R5
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $past(mode == DM_RESERVED) |-> (unpred && !grant)); // R6
  AST_FETCH_XN: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $past(mode == DM_CLIENT && acc == ACC_FETCH && xn_eff && !ap_unpred)
    |-> abort_kind == ABT_PREFETCH); // R10

endmodule

// File: tb/tb_perm_gate.sv
module tb_perm_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DOMAINS = 16;
  localparam int DOM_W = $clog2(NUM_DOMAINS);
  localparam int DAC_W = 2 * NUM_DOMAINS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DOM_W-1:0] dom_id;
  logic [DAC_W-1:0] dac_word;
  logic [2:0]       ap_code;
  logic [1:0]       hap_bits;
  logic             xn_bit;
  logic [1:0]       acc_kind;
  logic             priv;
  logic             wxn_en;
  logic             uwxn_en;
  logic [1:0]       legacy_prot;
  logic             grant;
  logic [1:0]       abort_kind;
  logic [1:0]       fault_cls;
  logic             unpred;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_gate #(.NUM_DOMAINS(NUM_DOMAINS)) dut (
    .clk(clk), .rst_n(rst_n), .dom_id(dom_id), .dac_word(dac_word),
    .ap_code(ap_code), .hap_bits(hap_bits), .xn_bit(xn_bit),
    .acc_kind(acc_kind), .priv(priv), .wxn_en(wxn_en), .uwxn_en(uwxn_en),
    .legacy_prot(legacy_prot), .grant(grant), .abort_kind(abort_kind),
    .fault_cls(fault_cls), .unpred(unpred)
  );

  // Expected {grant, abort[1:0], class[1:0], unpred} from the current inputs
  function automatic logic [5:0] model();
    int  m;
    bit  f, w, abt, wr, unp, x, h;
    m = int'((dac_word >> (int'(dom_id) * 2)) & 32'd3);
    f = (acc_kind == 2'd2);
    w = (acc_kind == 2'd1);
    if (m == 0) return {1'b0, (f ? 2'd1 : 2'd2), 2'd1, 1'b0};
    if (m == 3) return 6'b100000;
    if (m == 2) return 6'b000001;
    abt = 0; wr = 1; unp = 0;
    if (ap_code == 0) begin
      wr = 0;
      if (legacy_prot == 2'b10) abt = w || !priv;
      else if (legacy_prot == 2'b01) abt = w;
      else abt = 1;
    end else if (ap_code == 1) abt = !priv;
    else if (ap_code == 2) begin abt = !priv && w; wr = priv; end
    else if (ap_code == 4) begin unp = 1; wr = 0; end
    else if (ap_code == 5) begin abt = !priv || w; wr = 0; end
    else if (ap_code >= 6) begin abt = w; wr = 0; end
    if (unp) return 6'b000001;
    x = xn_bit || (wr && wxn_en) || (ap_code == 3 && uwxn_en && priv);
    h = w ? !hap_bits[1] : !hap_bits[0];
    if (f && (abt || x || h)) return {1'b0, 2'd1, 2'd2, 1'b0};
    if (!f && (abt || h)) return {1'b0, 2'd2, 2'd2, 1'b0};
    return 6'b100000;
  endfunction

  task automatic compare(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {grant, abort_kind, fault_cls, unpred};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // inputs already set after a negedge; they are sampled at the next posedge
  task automatic step(input string tag);
    logic [5:0] exp;
    exp = model();
    @(negedge clk);
    compare(exp, tag);
  endtask

  task automatic defaults();
    dac_word = {NUM_DOMAINS{2'b01}};
    dom_id = '0; ap_code = 3'd3; hap_bits = 2'b11; xn_bit = 0;
    acc_kind = 2'd0; priv = 1; wxn_en = 0; uwxn_en = 0; legacy_prot = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    defaults();
    dac_word = '1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare(6'b000000, "R1 reset");
    rst_n = 1;
    compare(6'b000000, "R1 before first edge");
    // R2: new inputs do not show before the edge
    defaults(); dac_word = '0;
    @(negedge clk);
    dac_word = '1;
    #1 compare({1'b0, 2'd2, 2'd1, 1'b0}, "R2 held between edges");
    step("R2 after edge");
    // R3: field selection at both ends
    defaults(); dac_word = {2'b11, {(NUM_DOMAINS-1){2'b00}}}; dom_id = DOM_W'(NUM_DOMAINS-1);
    step("R3 top domain manager");
    dom_id = '0; step("R3 bottom domain no access");
    dac_word = {{(NUM_DOMAINS-1){2'b11}}, 2'b00}; step("R3 neighbours ignored");
    // R4
    defaults(); dac_word = '0; acc_kind = 2'd2; step("R4 fetch domain");
    acc_kind = 2'd3; step("R4 read alt domain");
    acc_kind = 2'd1; ap_code = 3'd6; step("R11 domain beats permission");
    // R5
    defaults(); dac_word = '1; ap_code = 3'd0; hap_bits = 2'b00; xn_bit = 1;
    acc_kind = 2'd2; priv = 0; wxn_en = 1;
    step("R5 manager ignores all");
    // R6
    defaults(); dac_word = {NUM_DOMAINS{2'b10}}; step("R6 reserved mode");
    // R7
    defaults(); ap_code = 3'd0;
    for (int lp = 0; lp < 4; lp++) begin
      for (int k = 0; k < 2; k++) begin
        for (int p = 0; p < 2; p++) begin
          legacy_prot = 2'(lp); acc_kind = 2'(k); priv = p[0];
          step("R7 code 0 legacy");
        end
      end
    end
    // R8
    defaults();
    for (int a = 1; a < 8; a++) begin
      for (int k = 0; k < 2; k++) begin
        for (int p = 0; p < 2; p++) begin
          ap_code = 3'(a); acc_kind = 2'(k); priv = p[0];
          step("R8 code table");
        end
      end
    end
    // R9
    defaults(); hap_bits = 2'b01; acc_kind = 2'd1; step("R9 write blocked");
    acc_kind = 2'd0; step("R9 read allowed");
    hap_bits = 2'b10; step("R9 read blocked");
    acc_kind = 2'd2; step("R9 fetch blocked");
    // R10
    defaults(); acc_kind = 2'd2; ap_code = 3'd1; wxn_en = 1; step("R10 writable wxn");
    ap_code = 3'd5; step("R10 readonly no xn");
    ap_code = 3'd3; wxn_en = 0; uwxn_en = 1; step("R10 uwxn priv");
    priv = 0; step("R10 uwxn unpriv");
    priv = 1; uwxn_en = 0; xn_bit = 1; step("R10 entry xn");
    acc_kind = 2'd0; step("R11 xn ignored for read");
    // random, compared every clock
    for (int i = 0; i < 3000; i++) begin
      dac_word = {$urandom, $urandom} >> (64 - DAC_W);
      dom_id = DOM_W'($urandom); ap_code = 3'($urandom); hap_bits = 2'($urandom);
      xn_bit = 1'($urandom); acc_kind = 2'($urandom); priv = 1'($urandom);
      wxn_en = 1'($urandom); uwxn_en = 1'($urandom); legacy_prot = 2'($urandom);
      step("R11 random stream");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule